// File: doc/BRIEF.md
# Coherent Miss Transaction Tracker

This block follows one outstanding coherence miss on behalf of a cache controller in a broadcast protocol with a home directory. When the controller asks for a line, the tracker sends a read-for-sharing or a read-for-ownership request to the line's home node. It then counts the replies from every other cache and from memory, keeps the line data and its dirty bit, and notes whether any other cache still keeps a copy.

Once the last reply has arrived and data is in hand, the tracker reports the merged result for one cycle: the data, the dirty bit, the sharer flag and the exclusive flag. On the next cycle it sends an unblock message to the home node and becomes free again. Only one miss can be in flight at a time. A reply that arrives when no miss is waiting is dropped and flagged.

Top module: `miss_tracker`

## Requirements
- R1: After reset `req_ready` is 1, and `rqm_valid`, `done_valid`, `ub_valid` and `stray_err` are all 0.
- R2: A request accepted while `req_ready` is 1 produces, on the next cycle, a single-cycle `rqm_valid` with `rqm_addr` equal to the address, `rqm_write` equal to the request kind (0 = read for sharing, 1 = read for ownership), `rqm_src` equal to parameter `MY_ID`, and `rqm_home` equal to address bits [HOME_LSB+ID_W-1:HOME_LSB] (bits [5:4] at defaults).
- R3: At issue the pending count is loaded with `NUM_CACHES` (the other caches plus memory). Each accepted reply lowers it by its `rsp_acks`, saturating at zero.
- R4: While a miss is outstanding, `req_ready` is 0 and new requests are ignored: they produce no `rqm_valid` and do not change the tracked address.
- R5: Reply kinds are coded on `rsp_kind` as 0 = data, 1 = exclusive data, 2 = shared data, 3 = ack, 4 = shared ack. Kinds 0, 1 and 2 carry data: their `rsp_data` and `rsp_dirty` are captured, and a later clean data reply never replaces data already captured as dirty.
- R6: For a read-for-sharing miss, a reply of kind 2 or 4 sets the sharer flag. At completion `done_sharers` equals that flag and `done_excl` is its inverse.
- R7: For a read-for-ownership miss, completion always reports `done_excl` = 1 and `done_sharers` = 0, whatever reply kinds arrived.
- R8: `done_valid` pulses for one cycle, on the cycle after the reply that brings the pending count to zero, and only if data has been received by then.
- R9: On the cycle after `done_valid`, `ub_valid` pulses with `ub_addr` equal to the miss address and `ub_home` equal to its home node. `req_ready` returns to 1 in that same cycle.
- R10: A reply that arrives while no miss is waiting for replies is dropped. On the next cycle it causes a one-cycle `stray_err` pulse and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request strobe |
| req_write | input | 1 | 1 = read for ownership, 0 = read for sharing |
| req_addr | input | ADDR_W | Line address of the miss |
| req_ready | output | 1 | Tracker idle, request will be taken |
| rqm_valid | output | 1 | Outgoing request message strobe |
| rqm_write | output | 1 | Request kind in the message |
| rqm_addr | output | ADDR_W | Address in the message |
| rqm_src | output | ID_W | Requestor ID |
| rqm_home | output | ID_W | Destination home node |
| rsp_valid | input | 1 | Reply strobe |
| rsp_kind | input | 3 | Reply kind code |
| rsp_acks | input | CNT_W | Ack count the reply carries |
| rsp_data | input | DATA_W | Line data in a data reply |
| rsp_dirty | input | 1 | Dirty bit in a data reply |
| ub_valid | output | 1 | Unblock message strobe |
| ub_addr | output | ADDR_W | Unblock address |
| ub_home | output | ID_W | Unblock destination home node |
| done_valid | output | 1 | Completion strobe |
| done_data | output | DATA_W | Merged line data |
| done_dirty | output | 1 | Merged dirty bit |
| done_sharers | output | 1 | Another sharer exists |
| done_excl | output | 1 | Line granted exclusive |
| stray_err | output | 1 | Reply arrived while not waiting |

## Verification
A request message appears one cycle after the request edge. A completion appears one cycle after the edge that takes the last reply, and the unblock one cycle after that. A stray-reply flag appears one cycle after the stray reply. The driver presents inputs on falling edges and checks the request message on the next falling edge. It pushes the expected completion and unblock into queues, and a monitor on every falling edge pops and compares them only in the cycle each strobe is due. A strobe that shows up with an empty queue, or a queue left unpopped, counts as a failure.

// File: rtl/miss_tracker_pkg.sv
package miss_tracker_pkg;
  typedef enum logic [2:0] {
    RK_DATA      = 3'd0,
    RK_DATA_EXCL = 3'd1,
    RK_DATA_SHR  = 3'd2,
    RK_ACK       = 3'd3,
    RK_ACK_SHR   = 3'd4
  } rsp_kind_e;

  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_WAIT  = 2'd1,
    TS_UNBLK = 2'd2
  } trk_state_e;

  function automatic logic kind_has_data(input logic [2:0] k);
    return (k == RK_DATA) || (k == RK_DATA_EXCL) || (k == RK_DATA_SHR);
  endfunction

  function automatic logic kind_is_shared(input logic [2:0] k);
    return (k == RK_DATA_SHR) || (k == RK_ACK_SHR);
  endfunction
endpackage

// File: rtl/mt_pend_cnt.sv
module mt_pend_cnt #(
  parameter int CNT_W    = 3,
  parameter int LOAD_VAL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] dec_amt,
  output logic [CNT_W-1:0] cnt,
  output logic             hits_zero
);
  localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(LOAD_VAL);

  assign hits_zero = (dec_amt >= cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= LOAD_C;
    end else if (dec) begin
      cnt <= hits_zero ? '0 : cnt - dec_amt;
    end
  end

  AST_CNT_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |=> (cnt <= $past(cnt)));  // R3
endmodule

// File: rtl/mt_merge.sv
module mt_merge
  import miss_tracker_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic [2:0]        kind,
  input  logic [DATA_W-1:0] data,
  input  logic              dirty,
  output logic [DATA_W-1:0] data_q,
  output logic              dirty_q,
  output logic              got_q,
  output logic              shr_q,
  output logic              got_now
);
  logic is_data;
  assign is_data = kind_has_data(kind);
  assign got_now = got_q || (take && is_data);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      data_q  <= '0;
      dirty_q <= 1'b0;
      got_q   <= 1'b0;
      shr_q   <= 1'b0;
    end else if (take) begin
      if (is_data && (!dirty_q || dirty)) begin
        data_q  <= data;
        dirty_q <= dirty;
      end
      if (is_data) got_q <= 1'b1;
      if (kind_is_shared(kind)) shr_q <= 1'b1;
    end
  end

  AST_DIRTY_STICKS: assert property (@(posedge clk) disable iff (rst)
    (dirty_q && !clear) |=> dirty_q);  // R5
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
  import miss_tracker_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int ID_W       = 2,
  parameter int HOME_LSB   = 4,
  parameter int MY_ID      = 1,
  parameter int CNT_W      = $clog2(NUM_CACHES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rqm_valid,
  output logic              rqm_write,
  output logic [ADDR_W-1:0] rqm_addr,
  output logic [ID_W-1:0]   rqm_src,
  output logic [ID_W-1:0]   rqm_home,
  input  logic              rsp_valid,
  input  logic [2:0]        rsp_kind,
  input  logic [CNT_W-1:0]  rsp_acks,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_dirty,
  output logic              ub_valid,
  output logic [ADDR_W-1:0] ub_addr,
  output logic [ID_W-1:0]   ub_home,
  output logic              done_valid,
  output logic [DATA_W-1:0] done_data,
  output logic              done_dirty,
  output logic              done_sharers,
  output logic              done_excl,
  output logic              stray_err
);
  trk_state_e        st;
  logic [ADDR_W-1:0] line_q;
  logic              wr_q;
  logic              accept, take, fin;
  logic [CNT_W-1:0]  pend;
  logic              pend_zero;
  logic              got_q, got_now, shr_q;

  assign req_ready = (st == TS_IDLE);
  assign accept    = req_ready && req_valid;
  assign take      = rsp_valid && (st == TS_WAIT);
  assign fin       = take && pend_zero && got_now;

  mt_pend_cnt #(.CNT_W(CNT_W), .LOAD_VAL(NUM_CACHES)) u_cnt (
    .clk(clk), .rst(rst), .load(accept), .dec(take), .dec_amt(rsp_acks),
    .cnt(pend), .hits_zero(pend_zero)
  );

  mt_merge #(.DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst(rst), .clear(accept), .take(take), .kind(rsp_kind),
    .data(rsp_data), .dirty(rsp_dirty), .data_q(done_data), .dirty_q(done_dirty),
    .got_q(got_q), .shr_q(shr_q), .got_now(got_now)
  );

  assign rqm_addr     = line_q;
  assign rqm_write    = wr_q;
  assign rqm_src      = ID_W'(MY_ID);
  assign rqm_home     = line_q[HOME_LSB +: ID_W];
  assign ub_addr      = line_q;
  assign ub_home      = line_q[HOME_LSB +: ID_W];
  assign done_sharers = shr_q && !wr_q;
  assign done_excl    = wr_q || !shr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= TS_IDLE;
      line_q     <= '0;
      wr_q       <= 1'b0;
      rqm_valid  <= 1'b0;
      done_valid <= 1'b0;
      ub_valid   <= 1'b0;
      stray_err  <= 1'b0;
    end else begin
      rqm_valid  <= 1'b0;
      done_valid <= 1'b0;
      ub_valid   <= 1'b0;
      stray_err  <= rsp_valid && (st != TS_WAIT);
      case (st)
        TS_IDLE: if (req_valid) begin
          line_q    <= req_addr;
          wr_q      <= req_write;
          rqm_valid <= 1'b1;
          st        <= TS_WAIT;
        end
        TS_WAIT: if (fin) begin
          done_valid <= 1'b1;
          st         <= TS_UNBLK;
        end
        default: begin
          ub_valid <= 1'b1;
          st       <= TS_IDLE;
        end
      endcase
    end
  end

  AST_RQM_PULSE: assert property (@(posedge clk) disable iff (rst)
    rqm_valid |=> !rqm_valid);  // R2
  AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    rqm_valid |-> !req_ready);  // R4
  AST_DONE_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> got_q);  // R8
  AST_UNBLOCK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> (ub_valid && !done_valid));  // R9
  AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst)
    (done_valid && wr_q) |-> (done_excl && !done_sharers));  // R7
  AST_STRAY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && st == TS_IDLE) |=> !done_valid);  // R10
endmodule

// File: tb/miss_tracker_tb.sv
module miss_tracker_tb;
  localparam int NC = 4, AW = 16, DW = 32, IW = 2, CW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rqm_valid, rqm_write;
  logic [AW-1:0] rqm_addr, ub_addr;
  logic [IW-1:0] rqm_src, rqm_home, ub_home;
  logic rsp_valid = 0, rsp_dirty = 0;
  logic [2:0] rsp_kind = '0;
  logic [CW-1:0] rsp_acks = '0;
  logic [DW-1:0] rsp_data = '0;
  logic ub_valid, done_valid, done_dirty, done_sharers, done_excl, stray_err;
  logic [DW-1:0] done_data;

  int n_chk = 0, n_fail = 0;
  logic [63:0] exp_done_q[$];
  logic [AW-1:0] exp_ub_q[$];
  logic [AW-1:0] ub_pend = '0;
  bit ub_armed = 0;

  always #2 clk = ~clk;

  miss_tracker #(.NUM_CACHES(NC), .ADDR_W(AW), .DATA_W(DW), .ID_W(IW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .rqm_valid(rqm_valid),
    .rqm_write(rqm_write), .rqm_addr(rqm_addr), .rqm_src(rqm_src),
    .rqm_home(rqm_home), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_acks(rsp_acks), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
    .ub_valid(ub_valid), .ub_addr(ub_addr), .ub_home(ub_home),
    .done_valid(done_valid), .done_data(done_data), .done_dirty(done_dirty),
    .done_sharers(done_sharers), .done_excl(done_excl), .stray_err(stray_err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: completion and unblock scoreboard
  always @(negedge clk) if (!rst) begin
    if (ub_armed) begin
      chk(ub_valid == 1'b1, "R9 unblock due", {63'd0, ub_valid}, 64'd1);
      chk(ub_addr == ub_pend, "R9 unblock addr", {48'd0, ub_addr}, {48'd0, ub_pend});
      chk(ub_home == ub_pend[5:4], "R9 unblock home", {62'd0, ub_home}, {62'd0, ub_pend[5:4]});
      chk(req_ready == 1'b1, "R9 ready again", {63'd0, req_ready}, 64'd1);
      ub_armed = 0;
    end else if (ub_valid) begin
      chk(1'b0, "R9 unexpected unblock", 64'd1, 64'd0);
    end
    if (done_valid) begin
      if (exp_done_q.size() == 0) begin
        chk(1'b0, "R8 unexpected completion", 64'd1, 64'd0);
      end else begin
        logic [63:0] e;
        e = exp_done_q.pop_front();
        chk({done_data, done_dirty, done_sharers, done_excl} == e[34:0],
            "R5 R6 R7 completion fields",
            {29'd0, done_data, done_dirty, done_sharers, done_excl}, e);
        ub_pend  = exp_ub_q.pop_front();
        ub_armed = 1;
      end
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(rqm_valid == 1'b1, "R2 request sent", {63'd0, rqm_valid}, 64'd1);
    chk(rqm_addr == a && rqm_write == wr, "R2 request addr/kind", {47'd0, rqm_write, rqm_addr}, {47'd0, wr, a});
    chk(rqm_src == 2'd1 && rqm_home == a[5:4], "R2 request src/home", {60'd0, rqm_src, rqm_home}, {60'd0, 2'd1, a[5:4]});
    chk(req_ready == 1'b0, "R4 busy after issue", {63'd0, req_ready}, 64'd0);
  endtask

  task automatic reply(input logic [2:0] k, input logic [CW-1:0] n, input logic [DW-1:0] d, input bit dt);
    @(negedge clk);
    rsp_valid = 1; rsp_kind = k; rsp_acks = n; rsp_data = d; rsp_dirty = dt;
    @(posedge clk);
    #1 rsp_valid = 0;
  endtask

  task automatic expect_done(input logic [DW-1:0] d, input bit dt, input bit sh, input bit ex, input logic [AW-1:0] a);
    exp_done_q.push_back({29'd0, d, dt, sh, ex});
    exp_ub_q.push_back(a);
  endtask

  task automatic drain(input string tag);
    repeat (3) @(negedge clk);
    chk(exp_done_q.size() == 0, tag, exp_done_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(req_ready && !rqm_valid && !done_valid && !ub_valid && !stray_err, "R1 reset state",
        {59'd0, req_ready, rqm_valid, done_valid, ub_valid, stray_err}, 64'h10);

    // read, no sharers: three acks and memory data
    issue(0, 16'h1230);
    reply(3, 1, 0, 0); reply(3, 1, 0, 0); reply(3, 1, 0, 0);
    chk(done_valid == 0, "R8 no completion before last reply", {63'd0, done_valid}, 0);
    expect_done(32'hCAFE0001, 0, 0, 1, 16'h1230);
    reply(0, 1, 32'hCAFE0001, 0);
    drain("R3 R6 read exclusive completed");

    // read with a shared ack: sharers seen
    issue(0, 16'h0410);
    reply(0, 1, 32'h11112222, 0); reply(4, 1, 0, 0); reply(3, 1, 0, 0);
    expect_done(32'h11112222, 0, 1, 0, 16'h0410);
    reply(3, 1, 0, 0);
    drain("R6 read shared completed");

    // write with shared-type replies: still exclusive
    issue(1, 16'h0020);
    reply(4, 1, 0, 0); reply(2, 1, 32'h55AA55AA, 0); reply(3, 1, 0, 0);
    expect_done(32'h55AA55AA, 0, 0, 1, 16'h0020);
    reply(0, 1, 32'h55AA55AA, 0);
    drain("R7 write completed exclusive");

    // dirty owner data not replaced by later clean memory data; multi-ack reply
    issue(0, 16'h7730);
    reply(1, 1, 32'hD1D1D1D1, 1);
    reply(3, 2, 0, 0);
    chk(done_valid == 0, "R3 count not yet zero", {63'd0, done_valid}, 0);
    expect_done(32'hD1D1D1D1, 1, 0, 1, 16'h7730);
    reply(0, 1, 32'h0BAD0BAD, 0);
    drain("R5 dirty data kept");

    // request while busy ignored
    issue(1, 16'h0100);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 16'hFFF0;
    @(negedge clk);
    req_valid = 0;
    chk(rqm_valid == 0, "R4 busy request ignored", {63'd0, rqm_valid}, 0);
    chk(rqm_addr == 16'h0100, "R4 address kept", {48'd0, rqm_addr}, 64'h0100);
    reply(3, 1, 0, 0); reply(3, 1, 0, 0); reply(0, 1, 32'h00000042, 0);
    expect_done(32'h00000042, 0, 0, 1, 16'h0100);
    reply(3, 1, 0, 0);
    drain("R8 completion after busy request");

    // stray reply while idle
    reply(0, 1, 32'hEEEE, 1);
    @(negedge clk);
    chk(stray_err == 1, "R10 stray flagged", {63'd0, stray_err}, 1);
    chk(done_valid == 0 && req_ready == 1, "R10 stray dropped", {62'd0, done_valid, req_ready}, 1);
    @(negedge clk);
    chk(stray_err == 0, "R10 stray pulse one cycle", {63'd0, stray_err}, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule